// File: doc/BRIEF.md
# TDM Channel Slot Selector

This block decides, one word slot at a time, whether the current channel of a time-division multiplexed frame takes part in the transfer. It keeps two separate paths, one for transmit and one for receive. Each path has its own frame-sync and slot-advance strobes, its own slot counter and its own configuration. A serial frame engine drives the strobes. It reads back a per-slot enable, which tells it whether to shift out or accept a word, together with the index of the 16-channel block that the counter is in.

Each path works in one of three ways. When multichannel selection is off, every slot is enabled. In the extended scheme, each of up to 128 channels has its own bit in a 128-bit enable vector. In the legacy scheme, only two 16-channel blocks can be live at any time: one even-numbered block (partition A) and one odd-numbered block (partition B). Bits 15:0 of the enable vector gate partition A and bits 31:16 gate partition B. Configuration inputs are read live, and a change takes effect on the next registered output.

Top module: `tdm_slot_select`

## Requirements
- R1: While `rst` is high at a clock edge, both paths clear their slot counters to 0 and drive `*_slot_en` = 0 and `*_cur_blk` = 0 after that edge.
- R2: A high `*_fsync` at a clock edge sets that path's slot counter to 0. It takes priority over a `*_tick` sampled high at the same edge.
- R3: A high `*_tick` (without `*_fsync`) at a clock edge advances the slot counter by one. The counter wraps from slot NUM_CH-1 to slot 0.
- R4: `*_cur_blk` equals the slot index divided by 16, that is, slot bits 6:4 for 128 channels. It therefore changes only by +1 or by returning to 0.
- R5: When `*_mc_en` = 0, every slot is reported as enabled (`*_slot_en` = 1), whatever the other configuration inputs are.
- R6: When `*_mc_en` = 1 and `*_ext` = 1, slot n is enabled exactly when bit n of `*_en_vec` is 1.
- R7: When `*_mc_en` = 1 and `*_ext` = 0, slot n of block b (b = n/16, p = n mod 16) is enabled in two cases. The first is b = 2·`*_sel_a` and `*_en_vec`[p] = 1. The second is b = 2·`*_sel_b`+1 and `*_en_vec`[16+p] = 1. All other slots are disabled, and bits 127:32 of `*_en_vec` have no effect.
- R8: The transmit and receive paths are independent. No input of one path affects the outputs of the other.
- R9: The outputs are registered. `*_slot_en` and `*_cur_blk` at edge t+1 reflect the slot counter held after edge t and the configuration inputs sampled at edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fsync | input | 1 | Transmit frame start strobe |
| tx_tick | input | 1 | Transmit slot advance strobe |
| tx_mc_en | input | 1 | Transmit multichannel selection on |
| tx_ext | input | 1 | Transmit scheme: 0 legacy, 1 extended |
| tx_sel_a | input | 2 | Transmit partition A block pair (block 2·value) |
| tx_sel_b | input | 2 | Transmit partition B block pair (block 2·value+1) |
| tx_en_vec | input | 128 | Transmit channel enable bits |
| tx_slot_en | output | 1 | Transmit current slot enabled |
| tx_cur_blk | output | 3 | Transmit current 16-channel block |
| rx_fsync | input | 1 | Receive frame start strobe |
| rx_tick | input | 1 | Receive slot advance strobe |
| rx_mc_en | input | 1 | Receive multichannel selection on |
| rx_ext | input | 1 | Receive scheme: 0 legacy, 1 extended |
| rx_sel_a | input | 2 | Receive partition A block pair |
| rx_sel_b | input | 2 | Receive partition B block pair |
| rx_en_vec | input | 128 | Receive channel enable bits |
| rx_slot_en | output | 1 | Receive current slot enabled |
| rx_cur_blk | output | 3 | Receive current 16-channel block |

## Verification
The hardest cases to reach are the ones near the ends of a long frame. The legacy partition decode for blocks 6 and 7 is only seen after more than 96 slot advances, and the wrap from the last slot back to 0 only after 128. The bench walks a table of configurations. For each entry it steps a complete frame one slot at a time and then one slot further, so that it passes the wrap. Transmit and receive run from different table entries in the same frames. Directed cases then drive frame sync and tick in the same cycle, change the configuration in the middle of a frame, and fill the upper enable bits while the path is in the legacy scheme.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  typedef enum logic {
    SCHEME_LEGACY   = 1'b0,
    SCHEME_EXTENDED = 1'b1
  } scheme_e;

  localparam int unsigned LEGACY_PARTS = 2;
endpackage

// File: rtl/tss_slot_counter.sv
module tss_slot_counter #(
  parameter int unsigned NUM_CH = 128,
  localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH - 1);

  always_ff @(posedge clk) begin
    if (rst || fsync) begin
      slot <= '0;
    end else if (tick) begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end
  end
endmodule

// File: rtl/tss_enable_lookup.sv
module tss_enable_lookup
  import tdm_sel_pkg::*;
#(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned BLK_CH = 16,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(BLK_CH),
  localparam int unsigned BLK_W  = SLOT_W - BIT_W,
  localparam int unsigned PSEL_W = BLK_W - 1
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              mc_en,
  input  scheme_e           scheme,
  input  logic [PSEL_W-1:0] sel_a,
  input  logic [PSEL_W-1:0] sel_b,
  input  logic [NUM_CH-1:0] en_vec,
  output logic              en
);
  logic [BLK_W-1:0]  blk;
  logic [BIT_W-1:0]  pos;
  logic [BLK_CH-1:0] part_a_bits;
  logic [BLK_CH-1:0] part_b_bits;
  logic              in_a;
  logic              in_b;
  logic              legacy_en;

  assign blk         = slot[SLOT_W-1:BIT_W];
  assign pos         = slot[BIT_W-1:0];
  assign part_a_bits = en_vec[BLK_CH-1:0];
  assign part_b_bits = en_vec[LEGACY_PARTS*BLK_CH-1:BLK_CH];
  assign in_a        = (blk == {sel_a, 1'b0});
  assign in_b        = (blk == {sel_b, 1'b1});

  always_comb begin
    if (in_a)      legacy_en = part_a_bits[pos];
    else if (in_b) legacy_en = part_b_bits[pos];
    else           legacy_en = 1'b0;
  end

  always_comb begin
    if (!mc_en)                        en = 1'b1;
    else if (scheme == SCHEME_EXTENDED) en = en_vec[slot];
    else                               en = legacy_en;
  end
endmodule

// File: rtl/tss_direction.sv
module tss_direction
  import tdm_sel_pkg::*;
#(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned BLK_CH = 16,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(BLK_CH),
  localparam int unsigned BLK_W  = SLOT_W - BIT_W,
  localparam int unsigned PSEL_W = BLK_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              tick,
  input  logic              mc_en,
  input  logic              ext,
  input  logic [PSEL_W-1:0] sel_a,
  input  logic [PSEL_W-1:0] sel_b,
  input  logic [NUM_CH-1:0] en_vec,
  output logic              slot_en,
  output logic [BLK_W-1:0]  cur_blk
);
  logic [SLOT_W-1:0] slot;
  logic              en_comb;
  scheme_e           scheme;

  assign scheme = ext ? SCHEME_EXTENDED : SCHEME_LEGACY;

  tss_slot_counter #(.NUM_CH(NUM_CH)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .fsync (fsync),
    .tick  (tick),
    .slot  (slot)
  );

  tss_enable_lookup #(.NUM_CH(NUM_CH), .BLK_CH(BLK_CH)) u_lut (
    .slot   (slot),
    .mc_en  (mc_en),
    .scheme (scheme),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .en_vec (en_vec),
    .en     (en_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_en <= 1'b0;
      cur_blk <= '0;
    end else begin
      slot_en <= en_comb;
      cur_blk <= slot[SLOT_W-1:BIT_W];
    end
  end
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select #(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned BLK_CH = 16,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(BLK_CH),
  localparam int unsigned BLK_W  = SLOT_W - BIT_W,
  localparam int unsigned PSEL_W = BLK_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_fsync,
  input  logic              tx_tick,
  input  logic              tx_mc_en,
  input  logic              tx_ext,
  input  logic [PSEL_W-1:0] tx_sel_a,
  input  logic [PSEL_W-1:0] tx_sel_b,
  input  logic [NUM_CH-1:0] tx_en_vec,
  output logic              tx_slot_en,
  output logic [BLK_W-1:0]  tx_cur_blk,
  input  logic              rx_fsync,
  input  logic              rx_tick,
  input  logic              rx_mc_en,
  input  logic              rx_ext,
  input  logic [PSEL_W-1:0] rx_sel_a,
  input  logic [PSEL_W-1:0] rx_sel_b,
  input  logic [NUM_CH-1:0] rx_en_vec,
  output logic              rx_slot_en,
  output logic [BLK_W-1:0]  rx_cur_blk
);
  tss_direction #(.NUM_CH(NUM_CH), .BLK_CH(BLK_CH)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .fsync   (tx_fsync),
    .tick    (tx_tick),
    .mc_en   (tx_mc_en),
    .ext     (tx_ext),
    .sel_a   (tx_sel_a),
    .sel_b   (tx_sel_b),
    .en_vec  (tx_en_vec),
    .slot_en (tx_slot_en),
    .cur_blk (tx_cur_blk)
  );

  tss_direction #(.NUM_CH(NUM_CH), .BLK_CH(BLK_CH)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .fsync   (rx_fsync),
    .tick    (rx_tick),
    .mc_en   (rx_mc_en),
    .ext     (rx_ext),
    .sel_a   (rx_sel_a),
    .sel_b   (rx_sel_b),
    .en_vec  (rx_en_vec),
    .slot_en (rx_slot_en),
    .cur_blk (rx_cur_blk)
  );
endmodule

// File: rtl/tdm_slot_select_chk.sv
module tdm_slot_select_chk #(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned BLK_CH = 16,
  localparam int unsigned SLOT_W = $clog2(NUM_CH),
  localparam int unsigned BIT_W  = $clog2(BLK_CH),
  localparam int unsigned BLK_W  = SLOT_W - BIT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_fsync,
  input logic              tx_mc_en,
  input logic              tx_ext,
  input logic [NUM_CH-1:0] tx_en_vec,
  input logic              tx_slot_en,
  input logic [BLK_W-1:0]  tx_cur_blk,
  input logic              rx_fsync,
  input logic              rx_mc_en,
  input logic              rx_ext,
  input logic [NUM_CH-1:0] rx_en_vec,
  input logic              rx_slot_en,
  input logic [BLK_W-1:0]  rx_cur_blk
);
  // R2
  tx_fsync_blk0_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tx_fsync, 2) |-> (tx_cur_blk == '0));

  // R2
  rx_fsync_blk0_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rx_fsync, 2) |-> (rx_cur_blk == '0));

  // R4
  tx_blk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cur_blk != $past(tx_cur_blk)) |->
      (tx_cur_blk == BLK_W'($past(tx_cur_blk) + 1'b1) || tx_cur_blk == '0));

  // R4
  rx_blk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cur_blk != $past(rx_cur_blk)) |->
      (rx_cur_blk == BLK_W'($past(rx_cur_blk) + 1'b1) || rx_cur_blk == '0));

  // R5
  tx_mc_off_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!tx_mc_en)) |-> tx_slot_en);

  // R5
  rx_mc_off_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rx_mc_en)) |-> rx_slot_en);

  // R6
  tx_ext_none_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && tx_mc_en && tx_ext && tx_en_vec == '0) |-> !tx_slot_en);

  // R7
  tx_legacy_none_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && tx_mc_en && !tx_ext && tx_en_vec[2*BLK_CH-1:0] == '0)
      |-> !tx_slot_en);

  // R7
  rx_legacy_none_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rx_mc_en && !rx_ext && rx_en_vec[2*BLK_CH-1:0] == '0)
      |-> !rx_slot_en);
endmodule

bind tdm_slot_select tdm_slot_select_chk #(.NUM_CH(NUM_CH), .BLK_CH(BLK_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_fsync   (tx_fsync),
  .tx_mc_en   (tx_mc_en),
  .tx_ext     (tx_ext),
  .tx_en_vec  (tx_en_vec),
  .tx_slot_en (tx_slot_en),
  .tx_cur_blk (tx_cur_blk),
  .rx_fsync   (rx_fsync),
  .rx_mc_en   (rx_mc_en),
  .rx_ext     (rx_ext),
  .rx_en_vec  (rx_en_vec),
  .rx_slot_en (rx_slot_en),
  .rx_cur_blk (rx_cur_blk)
);

// File: tb/tdm_slot_select_tb.sv
module tdm_slot_select_tb;
  localparam int NUM_CH = 128;
  localparam int BLK_CH = 16;

  typedef struct packed {
    logic        mc;
    logic        ext;
    logic [1:0]  sa;
    logic [1:0]  sb;
    logic [31:0] seed;
  } cfg_t;

  // mc, ext, sel_a, sel_b, seed (0 = all clear, FFFFFFFF = all set)
  localparam cfg_t TABLE [8] = '{
    '{1'b0, 1'b1, 2'd0, 2'd0, 32'h1234_5678},
    '{1'b1, 1'b1, 2'd0, 2'd0, 32'hDEAD_BEEF},
    '{1'b1, 1'b1, 2'd0, 2'd0, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 2'd0, 2'd0, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 2'd3, 2'd3, 32'h0BAD_F00D},
    '{1'b1, 1'b0, 2'd1, 2'd2, 32'hC0FF_EE11},
    '{1'b1, 1'b1, 2'd2, 2'd1, 32'h0000_0000},
    '{1'b1, 1'b1, 2'd3, 2'd0, 32'h5A5A_A5A5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_fsync = 1'b0, tx_tick = 1'b0, tx_mc_en = 1'b0, tx_ext = 1'b0;
  logic [1:0] tx_sel_a = '0, tx_sel_b = '0;
  logic [NUM_CH-1:0] tx_en_vec = '0;
  logic tx_slot_en;
  logic [2:0] tx_cur_blk;
  logic rx_fsync = 1'b0, rx_tick = 1'b0, rx_mc_en = 1'b0, rx_ext = 1'b0;
  logic [1:0] rx_sel_a = '0, rx_sel_b = '0;
  logic [NUM_CH-1:0] rx_en_vec = '0;
  logic rx_slot_en;
  logic [2:0] rx_cur_blk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tdm_slot_select #(.NUM_CH(NUM_CH), .BLK_CH(BLK_CH)) u_dut (
    .clk(clk), .rst(rst),
    .tx_fsync(tx_fsync), .tx_tick(tx_tick), .tx_mc_en(tx_mc_en), .tx_ext(tx_ext),
    .tx_sel_a(tx_sel_a), .tx_sel_b(tx_sel_b), .tx_en_vec(tx_en_vec),
    .tx_slot_en(tx_slot_en), .tx_cur_blk(tx_cur_blk),
    .rx_fsync(rx_fsync), .rx_tick(rx_tick), .rx_mc_en(rx_mc_en), .rx_ext(rx_ext),
    .rx_sel_a(rx_sel_a), .rx_sel_b(rx_sel_b), .rx_en_vec(rx_en_vec),
    .rx_slot_en(rx_slot_en), .rx_cur_blk(rx_cur_blk)
  );

  function automatic logic [NUM_CH-1:0] make_vec(input logic [31:0] seed);
    logic [NUM_CH-1:0] v;
    if (seed == 32'h0) return '0;
    if (seed == 32'hFFFF_FFFF) return '1;
    for (int k = 0; k < NUM_CH / 32; k++) begin
      logic [31:0] x;
      x = seed ^ (32'(k + 1) * 32'h9E37_79B9);
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      v[32*k +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic ref_en(input logic mc, input logic ext,
                                  input logic [1:0] sa, input logic [1:0] sb,
                                  input logic [NUM_CH-1:0] v, input int slot);
    int blk = slot / BLK_CH;
    int p = slot % BLK_CH;
    if (!mc) return 1'b1;
    if (ext) return v[slot];
    if (blk == 2 * int'(sa)) return v[p];
    if (blk == 2 * int'(sb) + 1) return v[BLK_CH + p];
    return 1'b0;
  endfunction

  task automatic chk(input logic ok, input string req, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_slot(input int slot);
    logic te, re;
    te = ref_en(tx_mc_en, tx_ext, tx_sel_a, tx_sel_b, tx_en_vec, slot);
    re = ref_en(rx_mc_en, rx_ext, rx_sel_a, rx_sel_b, rx_en_vec, slot);
    chk(tx_slot_en == te, tx_ext ? "R6 tx slot enable" : "R7 tx slot enable",
        int'(tx_slot_en), int'(te));
    chk(rx_slot_en == re, "R8 rx slot enable", int'(rx_slot_en), int'(re));
    chk(int'(tx_cur_blk) == slot / BLK_CH, "R4 tx block", int'(tx_cur_blk), slot / BLK_CH);
    chk(int'(rx_cur_blk) == slot / BLK_CH, "R4 rx block", int'(rx_cur_blk), slot / BLK_CH);
  endtask

  task automatic frame_start();
    tx_fsync = 1'b1; rx_fsync = 1'b1;
    @(negedge clk);
    tx_fsync = 1'b0; rx_fsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic step();
    tx_tick = 1'b1; rx_tick = 1'b1;
    @(negedge clk);
    tx_tick = 1'b0; rx_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_slot_en == 1'b0, "R1 tx enable in reset", int'(tx_slot_en), 0);
    chk(tx_cur_blk == 3'd0, "R1 tx block in reset", int'(tx_cur_blk), 0);
    chk(rx_slot_en == 1'b0, "R1 rx enable in reset", int'(rx_slot_en), 0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: full frame plus the wrap (R3) per entry
    for (int i = 0; i < 8; i++) begin
      tx_mc_en = TABLE[i].mc; tx_ext = TABLE[i].ext;
      tx_sel_a = TABLE[i].sa; tx_sel_b = TABLE[i].sb;
      tx_en_vec = make_vec(TABLE[i].seed);
      rx_mc_en = TABLE[7-i].mc; rx_ext = TABLE[7-i].ext;
      rx_sel_a = TABLE[7-i].sa; rx_sel_b = TABLE[7-i].sb;
      rx_en_vec = make_vec(TABLE[7-i].seed ^ 32'h0F0F_0000);
      frame_start();
      check_slot(0);  // R2
      for (int s = 1; s <= NUM_CH; s++) begin
        step();
        check_slot(s % NUM_CH);  // R3 wrap at s == NUM_CH
      end
    end

    // R2: frame sync beats a simultaneous tick
    tx_mc_en = 1'b1; tx_ext = 1'b1; tx_en_vec = '0; tx_en_vec[0] = 1'b1;
    rx_mc_en = 1'b1; rx_ext = 1'b1; rx_en_vec = '0;
    repeat (5) step();
    tx_fsync = 1'b1; tx_tick = 1'b1;
    @(negedge clk);
    tx_fsync = 1'b0; tx_tick = 1'b0;
    @(negedge clk);
    chk(tx_slot_en == 1'b1, "R2 fsync priority enable", int'(tx_slot_en), 1);
    chk(tx_cur_blk == 3'd0, "R2 fsync priority block", int'(tx_cur_blk), 0);
    tx_tick = 1'b1;
    @(negedge clk);
    tx_tick = 1'b0;
    @(negedge clk);
    chk(tx_slot_en == 1'b0, "R6 slot 1 disabled", int'(tx_slot_en), 0);

    // R9: mid-frame configuration change seen on next edge; R8 rx untouched
    tx_mc_en = 1'b0;
    @(negedge clk);
    chk(tx_slot_en == 1'b1, "R9 mc off next cycle", int'(tx_slot_en), 1);
    chk(rx_slot_en == 1'b0, "R8 rx unaffected by tx", int'(rx_slot_en), 0);

    // R7: upper enable bits ignored in legacy scheme, block 2 slot 40
    tx_mc_en = 1'b1; tx_ext = 1'b0; tx_sel_a = 2'd1; tx_sel_b = 2'd0;
    tx_en_vec = '1; tx_en_vec[31:0] = '0;
    frame_start();
    for (int s = 1; s <= 40; s++) step();
    chk(tx_slot_en == 1'b0, "R7 upper bits ignored", int'(tx_slot_en), 0);
    chk(tx_cur_blk == 3'd2, "R4 block at slot 40", int'(tx_cur_blk), 2);
    tx_en_vec[8] = 1'b1;
    @(negedge clk);
    chk(tx_slot_en == 1'b1, "R7 partition A bit 8", int'(tx_slot_en), 1);

    // R1: reset mid-frame clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk(tx_cur_blk == 3'd0, "R1 block after reset", int'(tx_cur_blk), 0);
    chk(tx_slot_en == 1'b0, "R1 enable after reset", int'(tx_slot_en), 0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule